// File: doc/BRIEF.md
# Row-Hit-Aware SDRAM Read Sequencer

This block turns block-read requests from a motion-compensation engine into SDRAM commands for a multi-bank device. Each request names one row for every bank plus a base column. The block keeps an open-row table, with a valid flag and a row address for each bank. When a request is accepted, the block compares the rows it asks for against that table.

If every bank already holds the wanted row, the block goes straight to column reads. Otherwise it closes all banks with one precharge-all command, waits the precharge time, and activates the requested row in every bank in ascending bank order. It then waits the activate-to-read time after the last activate and issues the column reads.

Column reads walk across the banks in interleaved order. Read k goes to bank k mod NUM_BANKS at column base + k / NUM_BANKS. Since every row was opened up front, crossing between banks costs no cycles. Reads never carry the auto-precharge flag, so rows stay open for the next request to reuse. A read-data-valid output follows each read command after the CAS latency. One-cycle hit and miss pulses let a bench measure the miss rate.

Top module: `rowhit_seq`

## Requirements
- R1: After reset, and whenever no request is being served, `req_ready_o` is 1, `cmd_o` is NOP (code 0), bank and address are 0, and `rd_valid_o`, `row_hit_o` and `row_miss_o` are 0. Reset marks every bank closed, so the first request after a reset is always a miss.
- R2: When every bank's open row equals the requested row, the cycle after acceptance carries a one-cycle `row_hit_o` pulse and the first read command (code 2). No precharge or activate is issued for that request.
- R3: When any bank's open row is missing or differs, the cycle after acceptance carries a one-cycle `row_miss_o` pulse and a single precharge-all command (code 3) with address bit AP_BIT set to 1 and bank 0.
- R4: On a miss, the first activate (code 1) comes T_RP cycles after the precharge-all. One activate follows per cycle for banks 0 to NUM_BANKS-1 in ascending order, and each carries that bank's requested row as its address.
- R5: On a miss, the first read command comes T_RCD cycles after the last activate, and NOP is driven on every cycle between commands.
- R6: Each request issues READS_PER_REQ read commands on consecutive cycles. Read k uses bank k mod NUM_BANKS and column base + k / NUM_BANKS, placed in the low address bits, with address bit AP_BIT equal to 0.
- R7: `rd_valid_o` is high exactly CAS_LAT cycles after each read command, and low at all other times.
- R8: `req_ready_o` is 0 from the cycle after acceptance through the cycle of the last read command, and 1 in the next cycle. Request inputs presented while `req_ready_o` is 0 produce no commands and do not alter the rows that later requests see.
- R9: Rows stay open between requests. A request that differs from the open rows in only one bank still gets a full precharge-all and activates in all banks, and a repeat of it afterwards is a hit.
- R10: Exactly one of `row_hit_o` and `row_miss_o` pulses for one cycle per accepted request, and neither pulses otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle; request accepted when both are high |
| req_rows_i | input | NUM_BANKS*ROW_W | Requested row per bank, bank 0 in the low bits |
| req_col_i | input | COL_W | Base column of the request |
| cmd_o | output | 2 | 0 NOP, 1 activate, 2 read, 3 precharge-all |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ROW_W | Row for activate, column for read, AP_BIT set for precharge-all |
| rd_valid_o | output | 1 | Read data valid at the SDRAM data pins |
| row_hit_o | output | 1 | One-cycle pulse: request hit all open rows |
| row_miss_o | output | 1 | One-cycle pulse: request needed new rows |

## Verification
The hardest case to reach from the ports is the partial miss. Three banks already hold the right rows and only one differs, yet the block must still close and reopen every bank, and then count the request as a hit on a repeat. The stimulus table reaches this by opening a full row set, repeating it, and then changing one bank's row. Request inputs are also scrambled while the block is busy, so a later hit proves those inputs were ignored. A reset in the middle of the run, followed by the rows that were last open, shows that reset forgets them.

// File: rtl/rowhit_seq_pkg.sv
package rowhit_seq_pkg;
   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_ACT  = 2'd1,
      CMD_RD   = 2'd2,
      CMD_PREA = 2'd3
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WAIT,
      ST_ACT,
      ST_RD
   } seq_state_e;
endpackage

// File: rtl/rowhit_open_rows.sv
module rowhit_open_rows #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       set_i,
   input  logic [BANK_W-1:0]          set_bank_i,
   input  logic [ROW_W-1:0]           set_row_i,
   input  logic [NUM_BANKS*ROW_W-1:0] req_rows_i,
   output logic                       all_hit_o
);
   logic [NUM_BANKS-1:0] valid_q;
   logic [NUM_BANKS-1:0] match;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[b] <= 1'b0;
            row_q      <= '0;
         end else if (clr_i) begin
            valid_q[b] <= 1'b0;
         end else if (set_i && set_bank_i == BANK_W'(b)) begin
            valid_q[b] <= 1'b1;
            row_q      <= set_row_i;
         end
      end
      assign match[b] = valid_q[b] && (row_q == req_rows_i[b*ROW_W +: ROW_W]);
   end

   assign all_hit_o = &match;

   // R9
   prea_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> (valid_q == '0));
endmodule

// File: rtl/rowhit_rd_delay.sv
module rowhit_rd_delay #(
   parameter int CAS_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_issue_i,
   output logic rd_valid_o
);
   if (CAS_LAT == 1) begin : g_single
      logic vq;
      always_ff @(posedge clk) begin
         if (!rst_n) vq <= 1'b0;
         else        vq <= rd_issue_i;
      end
      assign rd_valid_o = vq;
   end else begin : g_shift
      logic [CAS_LAT-1:0] sr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sr_q <= '0;
         else        sr_q <= {sr_q[CAS_LAT-2:0], rd_issue_i};
      end
      assign rd_valid_o = sr_q[CAS_LAT-1];
   end
endmodule

// File: rtl/rowhit_fsm.sv
module rowhit_fsm
   import rowhit_seq_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int ROW_W         = 13,
   parameter int COL_W         = 10,
   parameter int AP_BIT        = 10,
   parameter int READS_PER_REQ = 8,
   parameter int T_RP          = 2,
   parameter int T_RCD         = 3,
   localparam int BANK_W       = $clog2(NUM_BANKS),
   localparam int RD_W         = $clog2(READS_PER_REQ),
   localparam int T_MAX        = (T_RP > T_RCD) ? T_RP : T_RCD,
   localparam int CNT_W        = $clog2(T_MAX) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid_i,
   input  logic [NUM_BANKS*ROW_W-1:0] req_rows_i,
   input  logic [COL_W-1:0]           req_col_i,
   input  logic                       all_hit_i,
   output logic                       req_ready_o,
   output sd_cmd_e                    cmd_o,
   output logic [BANK_W-1:0]          cmd_bank_o,
   output logic [ROW_W-1:0]           cmd_addr_o,
   output logic                       row_hit_o,
   output logic                       row_miss_o
);
   localparam logic [CNT_W-1:0]  RP_LOAD   = CNT_W'((T_RP > 1) ? T_RP - 2 : 0);
   localparam logic [CNT_W-1:0]  RCD_LOAD  = CNT_W'((T_RCD > 1) ? T_RCD - 2 : 0);
   localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
   localparam logic [RD_W-1:0]   LAST_RD   = RD_W'(READS_PER_REQ - 1);

   seq_state_e                 state_q, ret_q;
   logic [CNT_W-1:0]           cnt_q;
   logic [BANK_W-1:0]          act_idx_q;
   logic [RD_W-1:0]            rd_idx_q;
   logic [NUM_BANKS*ROW_W-1:0] rows_q;
   logic [COL_W-1:0]           col_q;
   logic                       hit_q, miss_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ret_q     <= ST_IDLE;
         cnt_q     <= '0;
         act_idx_q <= '0;
         rd_idx_q  <= '0;
         rows_q    <= '0;
         col_q     <= '0;
         hit_q     <= 1'b0;
         miss_q    <= 1'b0;
      end else begin
         hit_q  <= 1'b0;
         miss_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  rows_q    <= req_rows_i;
                  col_q     <= req_col_i;
                  act_idx_q <= '0;
                  rd_idx_q  <= '0;
                  if (all_hit_i) begin
                     hit_q   <= 1'b1;
                     state_q <= ST_RD;
                  end else begin
                     miss_q  <= 1'b1;
                     state_q <= ST_PRE;
                  end
               end
            end
            ST_PRE: begin
               if (T_RP > 1) begin
                  state_q <= ST_WAIT;
                  cnt_q   <= RP_LOAD;
                  ret_q   <= ST_ACT;
               end else begin
                  state_q <= ST_ACT;
               end
            end
            ST_WAIT: begin
               if (cnt_q == '0) state_q <= ret_q;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            ST_ACT: begin
               act_idx_q <= act_idx_q + 1'b1;
               if (act_idx_q == LAST_BANK) begin
                  if (T_RCD > 1) begin
                     state_q <= ST_WAIT;
                     cnt_q   <= RCD_LOAD;
                     ret_q   <= ST_RD;
                  end else begin
                     state_q <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               rd_idx_q <= rd_idx_q + 1'b1;
               if (rd_idx_q == LAST_RD) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_o      = CMD_NOP;
      cmd_bank_o = '0;
      cmd_addr_o = '0;
      case (state_q)
         ST_PRE: begin
            cmd_o              = CMD_PREA;
            cmd_addr_o[AP_BIT] = 1'b1;
         end
         ST_ACT: begin
            cmd_o      = CMD_ACT;
            cmd_bank_o = act_idx_q;
            cmd_addr_o = rows_q[act_idx_q*ROW_W +: ROW_W];
         end
         ST_RD: begin
            cmd_o      = CMD_RD;
            cmd_bank_o = rd_idx_q[BANK_W-1:0];
            cmd_addr_o = ROW_W'(col_q + COL_W'(rd_idx_q >> BANK_W));
         end
         default: ;
      endcase
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign row_hit_o   = hit_q;
   assign row_miss_o  = miss_q;

   // R2
   hit_first_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_hit_o |-> (cmd_o == CMD_RD && cmd_bank_o == '0));
   // R3
   miss_prea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_miss_o |-> (cmd_o == CMD_PREA));
endmodule

// File: rtl/rowhit_seq.sv
module rowhit_seq
   import rowhit_seq_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int ROW_W         = 13,
   parameter int COL_W         = 10,
   parameter int AP_BIT        = 10,
   parameter int READS_PER_REQ = 8,
   parameter int T_RP          = 2,
   parameter int T_RCD         = 3,
   parameter int CAS_LAT       = 2,
   localparam int BANK_W       = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid_i,
   output logic                       req_ready_o,
   input  logic [NUM_BANKS*ROW_W-1:0] req_rows_i,
   input  logic [COL_W-1:0]           req_col_i,
   output logic [1:0]                 cmd_o,
   output logic [BANK_W-1:0]          cmd_bank_o,
   output logic [ROW_W-1:0]           cmd_addr_o,
   output logic                       rd_valid_o,
   output logic                       row_hit_o,
   output logic                       row_miss_o
);
   initial begin
      banks_pow2_chk: assert (NUM_BANKS >= 2 && (NUM_BANKS & (NUM_BANKS - 1)) == 0)
         else $error("NUM_BANKS must be a power of two, at least 2");
      ap_pos_chk: assert (AP_BIT >= COL_W && AP_BIT < ROW_W)
         else $error("AP_BIT must lie above the column and inside the address");
      timing_chk: assert (T_RP >= 1 && T_RCD >= 1 && CAS_LAT >= 1 && READS_PER_REQ >= 2)
         else $error("timing parameters must be at least 1, reads at least 2");
   end

   sd_cmd_e cmd;
   logic    all_hit;
   logic    valid_i_gated;

   assign valid_i_gated = req_valid_i && req_ready_o;

   rowhit_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (cmd == CMD_PREA),
      .set_i      (cmd == CMD_ACT),
      .set_bank_i (cmd_bank_o),
      .set_row_i  (cmd_addr_o),
      .req_rows_i (req_rows_i),
      .all_hit_o  (all_hit)
   );

   rowhit_fsm #(
      .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
      .READS_PER_REQ(READS_PER_REQ), .T_RP(T_RP), .T_RCD(T_RCD)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (valid_i_gated),
      .req_rows_i  (req_rows_i),
      .req_col_i   (req_col_i),
      .all_hit_i   (all_hit),
      .req_ready_o (req_ready_o),
      .cmd_o       (cmd),
      .cmd_bank_o  (cmd_bank_o),
      .cmd_addr_o  (cmd_addr_o),
      .row_hit_o   (row_hit_o),
      .row_miss_o  (row_miss_o)
   );

   rowhit_rd_delay #(.CAS_LAT(CAS_LAT)) u_rdly (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_issue_i (cmd == CMD_RD),
      .rd_valid_o (rd_valid_o)
   );

   assign cmd_o = cmd;

   // R10
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_hit_o || row_miss_o) |-> $past(req_valid_i && req_ready_o));
   // R8
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> !req_ready_o);
   // R6
   rd_no_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD) |-> !cmd_addr_o[AP_BIT]);
endmodule

// File: tb/rowhit_seq_tb.sv
module rowhit_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 4;
   localparam int RW   = 13;
   localparam int CW   = 10;
   localparam int AP   = 10;
   localparam int NRD  = 8;
   localparam int TRP  = 2;
   localparam int TRCD = 3;
   localparam int CAS  = 2;
   localparam int NVEC = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [NB*RW-1:0] req_rows;
   logic [CW-1:0] req_col;
   logic [1:0]    cmd;
   logic [1:0]    cmd_bank;
   logic [RW-1:0] cmd_addr;
   logic          rd_valid, row_hit, row_miss;
   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rowhit_seq #(
      .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .AP_BIT(AP), .READS_PER_REQ(NRD),
      .T_RP(TRP), .T_RCD(TRCD), .CAS_LAT(CAS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_rows_i(req_rows), .req_col_i(req_col), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
      .cmd_addr_o(cmd_addr), .rd_valid_o(rd_valid), .row_hit_o(row_hit), .row_miss_o(row_miss)
   );

   // stimulus table: rows {bank3,bank2,bank1,bank0}, base column, expected hit
   localparam logic [NB*RW-1:0] V_ROWS [NVEC] = '{
      {13'd40, 13'd30, 13'd20, 13'd10},
      {13'd40, 13'd30, 13'd20, 13'd10},
      {13'd40, 13'd30, 13'd20, 13'd10},
      {13'd40, 13'd31, 13'd20, 13'd10},    // R9 single-bank difference
      {13'd40, 13'd31, 13'd20, 13'd10},
      {13'h1FFF, 13'd0, 13'd0, 13'h1FFF},
      {13'h1FFF, 13'd0, 13'd0, 13'h1FFF},
      {13'd40, 13'd31, 13'd20, 13'd10}
   };
   localparam logic [CW-1:0] V_COL [NVEC] = '{
      10'd0, 10'd8, 10'h100, 10'd3, 10'h3F0, 10'd17, 10'd0, 10'd64
   };
   localparam logic V_HIT [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

   task automatic check(input bit ok, input string tag, input logic [31:0] got,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic run_req(input logic [NB*RW-1:0] rows, input logic [CW-1:0] col,
                          input logic exp_hit);
      int rd_start, last_rd;
      rd_start = exp_hit ? 1 : (TRP + NB + TRCD);
      last_rd  = rd_start + NRD - 1;
      @(negedge clk);
      req_valid = 1'b1;
      req_rows  = rows;
      req_col   = col;
      check(req_ready === 1'b1, "R8 ready before request", {31'd0, req_ready}, 32'd1);
      @(posedge clk);
      for (int j = 1; j <= last_rd + CAS; j++) begin
         logic [1:0]    ec;
         logic [1:0]    eb;
         logic [RW-1:0] ea;
         logic          er, ev;
         string         tag;
         @(negedge clk);
         ec = 2'd0; eb = '0; ea = '0; tag = (j > last_rd) ? "R7" : "R5";
         if (!exp_hit && j == 1) begin
            ec = 2'd3; ea[AP] = 1'b1; tag = "R3/R9";
         end else if (!exp_hit && j >= 1 + TRP && j <= TRP + NB) begin
            ec = 2'd1; eb = 2'(j - 1 - TRP); ea = rows[(j-1-TRP)*RW +: RW]; tag = "R4";
         end else if (j >= rd_start && j <= last_rd) begin
            ec = 2'd2; eb = 2'((j - rd_start) % NB);
            ea = RW'(col + CW'((j - rd_start) / NB));
            tag = (exp_hit && j == 1) ? "R2" : "R6";
         end
         er = (j > last_rd);
         ev = (j - CAS >= rd_start) && (j - CAS <= last_rd);
         check({req_ready, cmd, cmd_bank, cmd_addr, rd_valid} === {er, ec, eb, ea, ev},
               tag, {13'd0, req_ready, cmd, cmd_bank, cmd_addr, rd_valid},
               {13'd0, er, ec, eb, ea, ev});
         check({row_hit, row_miss} === ((j == 1) ? {exp_hit, !exp_hit} : 2'b00),
               "R10 hit/miss pulse", {30'd0, row_hit, row_miss},
               (j == 1) ? {30'd0, exp_hit, !exp_hit} : 32'd0);
         if (j == 1) begin
            req_rows = {NB{13'h0ABC}};   // R8 scrambled while busy
            req_col  = 10'h2AA;
         end
         if (j == last_rd) req_valid = 1'b0;
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_rows = '0; req_col = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check({req_ready, cmd, cmd_bank, cmd_addr, rd_valid, row_hit, row_miss} ===
            {1'b1, 2'd0, 2'd0, 13'd0, 3'b000}, "R1 in reset",
            {12'd0, req_ready, cmd, cmd_bank, cmd_addr, rd_valid, row_hit, row_miss},
            32'h00100000);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check({req_ready, cmd, rd_valid, row_hit, row_miss} === 6'b100000, "R1 idle",
               {26'd0, req_ready, cmd, rd_valid, row_hit, row_miss}, 32'h20);
      end
      for (int v = 0; v < NVEC; v++) run_req(V_ROWS[v], V_COL[v], V_HIT[v]);
      // R1: reset forgets the open rows, so the last rows now miss
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run_req(V_ROWS[NVEC-1], 10'd5, 1'b0);
      run_req(V_ROWS[NVEC-1], 10'd6, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule